// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is an SPI master that software drives through a small 32-bit word register window. Software writes bytes into a transmit queue and fetches the returned bytes from a receive queue. A serial engine takes bytes off the transmit queue one at a time and shifts each one out on SCLK/MOSI, most significant bit first, in clock mode 0. It captures one byte from MISO for every byte it sends and pushes that byte into the receive queue.

A hold bit in the control register keeps queued bytes waiting. While it is set, software can load a whole command before any of it reaches the wire. When the bit is cleared, the queue drains back to back until it is empty. The slave-select outputs are active low. They are decoded from a software mask, and the lowest cleared bit of the mask picks the slave. The mask register drives the selects directly, so a select stays low across all the bytes of a transfer.

The control register can clear either queue. A keyed write resets the whole block. The block also exports level and pulse events for an external interrupt collector.

Top module: `spi_fifo_master`

## Requirements
- R1: A write of exactly 0x0000000A to offset 0x40 returns the block to its reset state: both queues empty, control register 0, slave mask 0x00000001. A write of any other value to 0x40 changes nothing.
- R2: The control register sits at offset 0x60. Bit 8 is the hold bit and reads back as written. Writing 1 to bit 5 empties the transmit queue, and writing 1 to bit 6 empties the receive queue. Bits 5 and 6 always read back as 0.
- R3: The status register at offset 0x64 reads bit 0 = receive queue empty, bit 1 = receive queue full, bit 2 = transmit queue empty and bit 3 = transmit queue full, with all other bits 0. Writes to it have no effect.
- R4: A write to offset 0x68 queues bits 7:0 of the write data for transmission. A write while the transmit queue holds FIFO_DEPTH bytes is dropped.
- R5: A read of offset 0x6C removes the oldest received byte and returns it zero-extended. When the receive queue is empty, the read returns 0xDEADBEEF and leaves the queue unchanged.
- R6: While the hold bit is 1, no byte starts on the wire and SCLK stays low. While it is 0, the transmit queue drains until it is empty.
- R7: Each byte is sent in mode 0, MSB first. SCLK idles low, each SCLK half period lasts CLK_DIV clock cycles, MISO is sampled on the rising SCLK edge and MOSI changes only while SCLK is low. Every sent byte yields one received byte, which enters the receive queue.
- R8: The slave mask at offset 0x70 resets to 1. The index of its lowest 0 bit selects slave_sel_n[index] low. If that index is at or above NUM_SS, or the mask has no 0 bit, all selects stay high.
- R9: A received byte that arrives while the receive queue is full is discarded, and evt_rx_overrun pulses high for one cycle.
- R10: Offset 0x74 reads the transmit queue occupancy and offset 0x78 reads the receive queue occupancy.
- R11: evt_tx_empty is high exactly when the transmit queue is empty, and evt_rx_avail is high exactly when the receive queue is not empty.
- R12: Read data appears on reg_rdata in the clock cycle after the read request. Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access request, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| slave_sel_n | output | NUM_SS | Active-low slave selects |
| evt_tx_empty | output | 1 | Transmit queue empty (level) |
| evt_rx_avail | output | 1 | Receive queue holds data (level) |
| evt_rx_overrun | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
The bench builds the block with FIFO_DEPTH = 8, NUM_SS = 3 and CLK_DIV = 2. The shallow queues let a few dozen bytes reach both the full-queue drop on the transmit side and the overrun discard on the receive side. Three selects leave mask indices at and above the select count, so the decoder's none-selected case is exercised. The short divider keeps each byte at 32 clock cycles, which leaves room for many randomized hold, queue and drain rounds. A bench slave returns a known byte sequence, so the bit order is checked in both directions.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam logic [7:0] OFS_SOFTRST = 8'h40;
    localparam logic [7:0] OFS_CTRL    = 8'h60;
    localparam logic [7:0] OFS_STAT    = 8'h64;
    localparam logic [7:0] OFS_TXDATA  = 8'h68;
    localparam logic [7:0] OFS_RXDATA  = 8'h6C;
    localparam logic [7:0] OFS_SSMASK  = 8'h70;
    localparam logic [7:0] OFS_TXLVL   = 8'h74;
    localparam logic [7:0] OFS_RXLVL   = 8'h78;

    localparam logic [31:0] SOFTRST_KEY   = 32'h0000_000A;
    localparam logic [31:0] EMPTY_READ    = 32'hDEAD_BEEF;
    localparam logic [31:0] SS_MASK_RESET = 32'h0000_0001;

    localparam int CTRL_TXCLR_BIT = 5;
    localparam int CTRL_RXCLR_BIT = 6;
    localparam int CTRL_HOLD_BIT  = 8;

    typedef struct packed {
        logic        hold;
        logic [31:0] ss_mask;
        logic [31:0] rdata;
        logic        ovr;
    } ctl_state_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [7:0]                   push_data,
    input  logic                         pop,
    output logic [7:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t q, d;
    logic [7:0]  mem [DEPTH];
    logic        do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign count   = q.cnt;
    assign head    = mem[q.rd];
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wr = ptr_inc(q.wr);
            if (do_pop)  d.rd = ptr_inc(q.rd);
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= push_data;
    end

    // R4
    fifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (q.cnt == $past(q.cnt)));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } shift_state_t;

    shift_state_t q, d;

    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_byte = q.rx;
    assign sclk    = q.sclk;
    assign mosi    = q.sh[7];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort) begin
            d.busy = 1'b0;
            d.sclk = 1'b0;
            d.cnt  = '0;
            d.bitn = '0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sclk = 1'b0;
                d.cnt  = '0;
                d.bitn = '0;
                d.sh   = tx_byte;
            end
        end else if (q.cnt == CNT_W'(HALF_DIV - 1)) begin
            d.cnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.sh   = {q.sh[6:0], 1'b0};
                    d.bitn = q.bitn + 3'd1;
                end
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sclk);

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(q.sh[7]));

endmodule

// File: rtl/spi_ss_decode.sv
module spi_ss_decode #(
    parameter int NUM_SS = 4
) (
    input  logic [31:0]       mask,
    output logic [NUM_SS-1:0] sel_n
);
    logic [5:0] idx;
    logic       found;

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (!mask[i]) begin
                idx   = 6'(i);
                found = 1'b1;
            end
        end
    end

    for (genvar j = 0; j < NUM_SS; j++) begin : g_sel
        assign sel_n[j] = !(found && (idx == 6'(j)));
    end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    parameter int NUM_SS     = 4,
    parameter int CLK_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_SS-1:0] slave_sel_n,
    output logic              evt_tx_empty,
    output logic              evt_rx_avail,
    output logic              evt_rx_overrun
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctl_state_t q, d;

    logic             wr_req, rd_req, srst;
    logic             tx_clr, rx_clr, tx_push, rx_pop, rx_push;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_head;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             eng_start, eng_busy, eng_done;
    logic [7:0]       eng_rx;

    assign wr_req  = reg_sel && reg_wr;
    assign rd_req  = reg_sel && !reg_wr;
    assign srst    = wr_req && (reg_addr == OFS_SOFTRST) && (reg_wdata == SOFTRST_KEY);
    assign tx_clr  = srst || (wr_req && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_TXCLR_BIT]);
    assign rx_clr  = srst || (wr_req && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_RXCLR_BIT]);
    assign tx_push = wr_req && (reg_addr == OFS_TXDATA);
    assign rx_pop  = rd_req && (reg_addr == OFS_RXDATA);
    assign rx_push = eng_done;

    assign eng_start = !q.hold && !tx_empty && !eng_busy && !tx_clr;

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .push_data(reg_wdata[7:0]),
        .pop(eng_start), .head(tx_head), .count(tx_count),
        .empty(tx_empty), .full(tx_full)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .push_data(eng_rx),
        .pop(rx_pop), .head(rx_head), .count(rx_count),
        .empty(rx_empty), .full(rx_full)
    );

    spi_byte_shifter #(.HALF_DIV(CLK_DIV)) i_shifter (
        .clk(clk), .rst_n(rst_n), .abort(srst),
        .start(eng_start), .tx_byte(tx_head), .miso(spi_miso),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    spi_ss_decode #(.NUM_SS(NUM_SS)) i_ss_decode (
        .mask(q.ss_mask), .sel_n(slave_sel_n)
    );

    always_comb begin
        d     = q;
        d.ovr = rx_push && rx_full && !rx_clr;
        if (rd_req) begin
            unique case (reg_addr)
                OFS_CTRL:   d.rdata = 32'(q.hold) << CTRL_HOLD_BIT;
                OFS_STAT:   d.rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
                OFS_RXDATA: d.rdata = rx_empty ? EMPTY_READ : {24'd0, rx_head};
                OFS_SSMASK: d.rdata = q.ss_mask;
                OFS_TXLVL:  d.rdata = 32'(tx_count);
                OFS_RXLVL:  d.rdata = 32'(rx_count);
                default:    d.rdata = '0;
            endcase
        end
        if (srst) begin
            d.hold    = 1'b0;
            d.ss_mask = SS_MASK_RESET;
            d.ovr     = 1'b0;
        end else if (wr_req && reg_addr == OFS_CTRL) begin
            d.hold = reg_wdata[CTRL_HOLD_BIT];
        end else if (wr_req && reg_addr == OFS_SSMASK) begin
            d.ss_mask = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ss_mask <= SS_MASK_RESET;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata      = q.rdata;
    assign evt_tx_empty   = tx_empty;
    assign evt_rx_avail   = !rx_empty;
    assign evt_rx_overrun = q.ovr;

    // R8
    ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~slave_sel_n));

    // R6
    hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold && !eng_busy) |=> !eng_busy);

    // R9
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_overrun |-> $past(rx_full));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty && !rx_push && !rx_clr) |=> (rx_count == '0));

endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
    localparam int DEPTH  = 8;
    localparam int NSS    = 3;
    localparam int DIV    = 2;
    localparam int BYTE_T = 16 * DIV + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic spi_sclk, spi_mosi, spi_miso;
    logic [NSS-1:0] slave_sel_n;
    logic evt_tx_empty, evt_rx_avail, evt_rx_overrun;

    int n_chk = 0, n_fail = 0;
    int sclk_rises = 0, ovr_seen = 0, exp_ovr = 0;
    int k_cap = 0, k_load = 1, nbit = 0;
    bit armed = 0, load_pending = 0;
    logic [7:0] mosi_sh, slv_sh;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #4 clk = ~clk;

    spi_fifo_master #(.FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(DIV)) i_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .slave_sel_n(slave_sel_n), .evt_tx_empty(evt_tx_empty),
        .evt_rx_avail(evt_rx_avail), .evt_rx_overrun(evt_rx_overrun)
    );

    function automatic logic [7:0] slv_pat(input int k);
        return 8'(k * 37 + 11);
    endfunction

    function automatic logic [NSS-1:0] exp_ss(input logic [31:0] m);
        logic [NSS-1:0] r = '1;
        for (int i = 0; i < 32; i++) begin
            if (!m[i]) begin
                if (i < NSS) r[i] = 1'b0;
                break;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_stat(input int txc, input int rxc);
        return {28'd0, txc == DEPTH, txc == 0, rxc == DEPTH, rxc == 0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    assign spi_miso = slv_sh[7];

    // bench slave: captures MOSI on rising SCLK, shifts MISO on falling SCLK
    always @(posedge spi_sclk) if (armed) begin
        sclk_rises++;
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        nbit++;
        if (nbit == 8) begin
            nbit = 0;
            load_pending = 1;
            if (exp_tx.size() == 0) chk("R7 unexpected byte", 32'(mosi_sh), 32'hFFFF_FFFF);
            else chk("R7 mosi byte", 32'(mosi_sh), 32'(exp_tx.pop_front()));
            if (exp_rx.size() < DEPTH) exp_rx.push_back(slv_pat(k_cap));
            else exp_ovr++;
            k_cap++;
        end
    end

    always @(negedge spi_sclk) if (armed) begin
        if (load_pending) begin
            slv_sh = slv_pat(k_load);
            k_load++;
            load_pending = 0;
        end else begin
            slv_sh = {slv_sh[6:0], 1'b0};
        end
    end

    always @(negedge clk) if (armed && evt_rx_overrun) ovr_seen++;

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_sel = 1'b0;
        v = reg_rdata;
    endtask

    task automatic push_tx(input logic [31:0] v);
        wr(8'h68, v);
        if (exp_tx.size() < DEPTH) exp_tx.push_back(v[7:0]);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic drain(input int n);
        wr(8'h60, 32'h0);
        repeat (n * BYTE_T + 20) @(posedge clk);
        wr(8'h60, 32'h100);
    endtask

    task automatic read_rx_all(input string req);
        int n = exp_rx.size();
        for (int i = 0; i < n; i++) rd_chk(req, 8'h6C, 32'(exp_rx.pop_front()));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] m;
        int n;
        void'($urandom(32'd20240501));
        slv_sh = slv_pat(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);

        // reset state
        rd_chk("R3 reset status", 8'h64, 32'h5);
        rd_chk("R1 reset ctrl", 8'h60, 32'h0);
        rd_chk("R8 reset mask", 8'h70, 32'h1);
        chk("R8 reset selects", 32'(slave_sel_n), 32'(3'b101));
        chk("R11 tx empty event", 32'(evt_tx_empty), 32'h1);
        chk("R11 rx avail event", 32'(evt_rx_avail), 32'h0);
        chk("R7 sclk idle", 32'(spi_sclk), 32'h0);
        rd_chk("R12 unmapped", 8'h10, 32'h0);
        wr(8'h64, 32'hFFFF_FFFF);
        rd_chk("R3 status write ignored", 8'h64, 32'h5);
        rd_chk("R5 empty read", 8'h6C, 32'hDEAD_BEEF);
        rd_chk("R5 empty read count", 8'h78, 32'h0);

        // slave select decode
        foreach (m[i]) if (i < 0) m = 0;
        for (int t = 0; t < 6; t++) begin
            case (t)
                0: m = 32'hFFFF_FFFE;
                1: m = 32'hFFFF_FFFB;
                2: m = 32'hFFFF_FFF7;
                3: m = 32'h0;
                4: m = 32'hFFFF_FFFF;
                default: m = 32'h7FFF_FFFF;
            endcase
            wr(8'h70, m);
            chk("R8 select decode", 32'(slave_sel_n), 32'(exp_ss(m)));
        end
        rd_chk("R8 mask readback", 8'h70, m);

        // hold: bytes queue, no clock
        wr(8'h60, 32'h100);
        rd_chk("R2 hold readback", 8'h60, 32'h100);
        for (int i = 0; i < 3; i++) push_tx(32'hABCD_1200 | 32'(8'hA0 + i));
        repeat (60) @(posedge clk);
        chk("R6 no sclk while hold", 32'(sclk_rises), 32'h0);
        rd_chk("R10 tx level", 8'h74, 32'd3);
        rd_chk("R11 tx empty event low", 32'h0 | 8'h00, 32'h0);
        chk("R11 tx event", 32'(evt_tx_empty), 32'h0);
        for (int i = 0; i < 5; i++) push_tx(32'(8'h3C + i));
        rd_chk("R3 tx full status", 8'h64, 32'h9);
        push_tx(32'h55);
        rd_chk("R4 drop when full", 8'h74, 32'(DEPTH));

        // drain into a full receive queue
        drain(DEPTH);
        chk("R7 sclk edges", 32'(sclk_rises), 32'(8 * DEPTH));
        rd_chk("R10 rx level", 8'h78, 32'(DEPTH));
        rd_chk("R3 rx full status", 8'h64, 32'h6);
        chk("R11 rx avail", 32'(evt_rx_avail), 32'h1);
        read_rx_all("R7 rx byte");
        rd_chk("R5 status after reads", 8'h64, 32'h5);

        // overrun
        for (int i = 0; i < DEPTH; i++) push_tx(32'($urandom));
        drain(DEPTH);
        for (int i = 0; i < 2; i++) push_tx(32'($urandom));
        drain(2);
        chk("R9 overrun pulses", 32'(ovr_seen), 32'(exp_ovr));
        chk("R9 overrun count", 32'(exp_ovr), 32'd2);
        rd_chk("R9 rx still full", 8'h78, 32'(DEPTH));
        read_rx_all("R9 kept bytes");

        // queue clears through control
        for (int i = 0; i < 3; i++) push_tx(32'($urandom));
        wr(8'h60, 32'h120);
        exp_tx.delete();
        rd_chk("R2 tx clear", 8'h74, 32'h0);
        rd_chk("R2 clear bits read 0", 8'h60, 32'h100);
        push_tx(32'h96);
        drain(1);
        rd_chk("R7 one byte back", 8'h78, 32'h1);
        wr(8'h60, 32'h140);
        exp_rx.delete();
        rd_chk("R2 rx clear", 8'h78, 32'h0);
        rd_chk("R2 ctrl after rx clear", 8'h60, 32'h100);

        // soft reset
        for (int i = 0; i < 3; i++) push_tx(32'($urandom));
        wr(8'h70, 32'hFFFF_FFF0);
        wr(8'h40, 32'h0000_000B);
        rd_chk("R1 wrong key ignored", 8'h74, 32'h3);
        rd_chk("R1 wrong key ctrl", 8'h60, 32'h100);
        wr(8'h40, 32'h0000_000A);
        exp_tx.delete();
        rd_chk("R1 tx cleared", 8'h74, 32'h0);
        rd_chk("R1 ctrl cleared", 8'h60, 32'h0);
        rd_chk("R1 mask reset", 8'h70, 32'h1);
        rd_chk("R1 status reset", 8'h64, 32'h5);
        wr(8'h60, 32'h100);

        // random rounds
        for (int r = 0; r < 20; r++) begin
            n = 1 + int'($urandom_range(DEPTH - 1));
            for (int i = 0; i < n; i++) push_tx($urandom);
            rd_chk("R10 random tx level", 8'h74, 32'(n));
            rd_chk("R3 random status", 8'h64, exp_stat(n, 0));
            drain(n);
            rd_chk("R10 random rx level", 8'h78, 32'(n));
            read_rx_all("R7 random rx byte");
            m = $urandom;
            if (r % 2 == 0) m = m | 32'hFFFF_FFF8;
            wr(8'h70, m);
            chk("R8 random select", 32'(slave_sel_n), 32'(exp_ss(m)));
        end
        chk("R9 no extra overrun", 32'(ovr_seen), 32'(exp_ovr));
        finish_run();
    end

endmodule